// File: doc/BRIEF.md
# Word-Wide Direct I/O Port with Timing Strobes

This block sits next to a processor and moves a full 32-bit word in one command to or from an external device over parallel static wires. A write command places the word on a bank of output lines and leaves it there until the next write. A read command samples a bank of input lines and hands the captured word back to the processor.

Every command also carries an 8-bit immediate. Each set bit of the immediate raises its own strobe line toward the device for a fixed number of clocks, and all selected strobes rise and fall together. On a write, the output lines change one cycle before the strobes rise, so the device can use a strobe edge as a data-valid signal. On a read, the input lines pass through a two-flop synchroniser and are captured on the edge where the strobes end.

The processor side uses a valid/ready handshake. The block takes one command at a time. A single-cycle completion flag follows the strobe window, and new commands are held off until that flag has been shown.

Top module: `dword_port`

## Requirements
- R1: After reset, `dout`, `rd_data`, `tpulse` and `done` are all zero and `cmd_ready` is high.
- R2: A command with `cmd_op` = 0xB4 accepted on a clock edge loads `cmd_wdata` onto `dout` at that same edge. `dout` then holds its value until the next accepted 0xB4 command.
- R3: For a command with `cmd_op` = 0xB5, `rd_data` takes the value `din` had two clock edges before the edge where the strobes end. This is the edge that raises `done`. `rd_data` changes at no other time.
- R4: Bit i of the immediate drives `tpulse[i]`. All set bits go high together on the edge after acceptance and stay high for exactly PULSE_CYC cycles. Clear bits stay low.
- R5: `done` is high for exactly one cycle, directly after the last strobe cycle. That is PULSE_CYC+1 cycles after the accepting edge.
- R6: `cmd_ready` falls on the accepting edge of a 0xB4 or 0xB5 command and rises again on the edge that ends `done`. A command offered while `cmd_ready` is low is not taken.
- R7: An immediate of zero produces no strobe. The command keeps the same timing, and its data transfer still takes place.
- R8: A command with any other opcode is consumed in one cycle. It raises no `done` and no strobe, and it leaves `dout` and `rd_data` unchanged.
- R9: Both directions carry all 32 bits, including the upper 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 8 | Opcode: 0xB4 write, 0xB5 read |
| cmd_imm | input | PW | Strobe select immediate |
| cmd_wdata | input | DW | Word to drive on a write |
| done | output | 1 | One-cycle completion flag |
| rd_data | output | DW | Last word captured by a read |
| dout | output | DW | Static output lines toward the device |
| din | input | DW | Input lines from the device |
| tpulse | output | PW | Timing strobe lines |

## Verification
The bench builds the port with a 32-bit word, eight strobe lines and PULSE_CYC = 3. The short strobe window keeps each command to five cycles, so a single run can cover hundreds of back-to-back commands. With the full word width, the bench can use patterns that differ only in the upper bytes. Driving `din` with new random values on every cycle makes the two-edge synchroniser delay visible in `rd_data`. Holding `cmd_valid` high through a busy window shows whether commands are refused while the block is busy.

// File: rtl/dword_port.sv
module dword_port #(
  parameter int DW        = 32,
  parameter int PW        = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_op,
  input  logic [PW-1:0] cmd_imm,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] din,
  output logic [PW-1:0] tpulse
);
  localparam logic [7:0] OP_WR = 8'hB4;
  localparam logic [7:0] OP_RD = 8'hB5;
  localparam int CW = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] imm_q;
  logic          is_rd;
  logic [DW-1:0] sync1, sync2;

  wire take  = cmd_valid && cmd_ready;
  wire go_wr = take && cmd_op == OP_WR;
  wire go_rd = take && cmd_op == OP_RD;

  assign cmd_ready = st == S_IDLE;
  assign done      = st == S_FIN;
  assign tpulse    = (st == S_PULSE) ? imm_q : '0;

  always_ff @(posedge clk) begin
    sync1 <= din;
    sync2 <= sync1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      imm_q   <= '0;
      is_rd   <= 1'b0;
      dout    <= '0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (go_wr || go_rd) begin
          st    <= S_SETUP;
          imm_q <= cmd_imm;
          is_rd <= go_rd;
          if (go_wr) dout <= cmd_wdata;
        end
        S_SETUP: begin
          st  <= S_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end
        S_PULSE: if (cnt == '0) begin
          st <= S_FIN;
          if (is_rd) rd_data <= sync2;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_dout_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |=> dout == $past(cmd_wdata));
  p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !go_wr |=> $stable(dout));
  p_rd_only_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
  p_pulse_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|tpulse) |-> (!cmd_ready && !done));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready);
  p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr || go_rd) |=> !cmd_ready);
  p_other_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !go_wr && !go_rd) |=> (cmd_ready && !done));
endmodule

// File: tb/tb_dword_port.sv
module tb_dword_port;
  localparam int DW = 32, PW = 8, P = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_op = 0;
  logic [PW-1:0] cmd_imm = 0;
  logic [DW-1:0] cmd_wdata = 0, din = 0;
  logic cmd_ready, done;
  logic [DW-1:0] rd_data, dout;
  logic [PW-1:0] tpulse;

  int total = 0, bad = 0, cyc = 0;
  int pulse_cyc_seen = 0, done_seen = 0;

  dword_port #(.DW(DW), .PW(PW), .PULSE_CYC(P)) dut (.*);

  always #2 clk = ~clk;

  // behavioural reference
  int ph = 0;
  logic is_rd_m = 0;
  logic [PW-1:0] imm_m = 0;
  logic [DW-1:0] dout_m = 0, rd_m = 0, h1 = 0, h2 = 0;

  always @(posedge clk) begin
    logic [DW-1:0] old2;
    old2 = h2;
    h2 = h1;
    h1 = din;
    if (!rst_n) begin
      ph = 0; dout_m = 0; rd_m = 0; imm_m = 0; is_rd_m = 0;
    end else if (ph == 0) begin
      if (cmd_valid && (cmd_op == 8'hB4 || cmd_op == 8'hB5)) begin
        ph = 1; imm_m = cmd_imm; is_rd_m = (cmd_op == 8'hB5);
        if (!is_rd_m) dout_m = cmd_wdata;
      end
    end else if (ph == P + 2) begin
      ph = 0;
    end else begin
      if (ph == P + 1 && is_rd_m) rd_m = old2;
      ph++;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 dout", dout, dout_m);
      chk("R3 rd_data", rd_data, rd_m);
      chk("R4 tpulse", DW'(tpulse), DW'((ph >= 2 && ph <= P + 1) ? imm_m : 0));
      chk("R5 done", DW'(done), DW'(ph == P + 2));
      chk("R6 ready", DW'(cmd_ready), DW'(ph == 0));
      if (|tpulse) pulse_cyc_seen++;
      if (done) done_seen++;
    end
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input logic [7:0] op, input logic [PW-1:0] imm, input logic [DW-1:0] wd);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_imm = imm; cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dout", dout, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 tpulse", DW'(tpulse), 0);
    chk("R1 done", DW'(done), 0);
    chk("R1 ready", DW'(cmd_ready), 1);
    rst_n = 1;

    issue(8'hB4, 8'hA5, 32'hDEADBEEF); wait_idle();
    chk("R9 write upper bits", dout, 32'hDEADBEEF);
    din = 32'h12345678;
    issue(8'hB5, 8'h01, 0); wait_idle();
    chk("R9 read upper bits", rd_data, 32'h12345678);

    pulse_cyc_seen = 0; done_seen = 0;
    issue(8'hB4, 8'h00, 32'hFFFF0000); wait_idle();
    chk("R7 no strobe", DW'(pulse_cyc_seen), 0);
    chk("R7 done still", DW'(done_seen), 1);
    chk("R7 write done", dout, 32'hFFFF0000);
    din = 32'h80000001;
    issue(8'hB5, 8'h00, 0); wait_idle();
    chk("R7 read done", rd_data, 32'h80000001);

    pulse_cyc_seen = 0; done_seen = 0;
    issue(8'hB3, 8'hFF, 32'h0BADF00D);
    repeat (P + 3) @(negedge clk);
    chk("R8 dout kept", dout, 32'hFFFF0000);
    chk("R8 rd kept", rd_data, 32'h80000001);
    chk("R8 no done", DW'(done_seen), 0);
    chk("R8 no strobe", DW'(pulse_cyc_seen), 0);

    pulse_cyc_seen = 0;
    issue(8'hB4, 8'hFF, 32'h55AA55AA);
    cmd_valid = 1; cmd_op = 8'hB5; cmd_imm = 8'h80;
    chk("R6 held off", DW'(cmd_ready), 0);
    repeat (P + 4) @(negedge clk);
    cmd_valid = 0;
    wait_idle();
    chk("R4 strobe width", DW'(pulse_cyc_seen), 2 * P);

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      din = $urandom;
      cmd_valid = ($urandom % 3) != 0;
      case ($urandom % 4)
        0: cmd_op = 8'hB4;
        1: cmd_op = 8'h00;
        default: cmd_op = 8'hB5;
      endcase
      cmd_imm = $urandom;
      cmd_wdata = $urandom;
    end
    cmd_valid = 0;
    wait_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule